// File: doc/BRIEF.md
# Programming Mode Entry Controller

This controller decides when a small microcontroller stops normal execution and enters in-circuit programming. It watches a detector that reports a programming-level voltage on the reset/programming pin, and a detector that reports an ordinary supply-level voltage on that pin. It also watches a programming-request pin, an optional second high-voltage input on an alternate debug port, and a selector pin for reduced-pin emulation. It combines these with latched configuration bits. The voltage sensing itself, the flash array and the serial programming protocol are handled elsewhere.

There are two ways in. The high-voltage path always works. The single-supply path works only while the single-supply enable bit is set, and only the high-voltage path may change that bit. While the single-supply bit is set, the programming-request pin belongs to entry control and its general-purpose function is switched off. The block also decides whether an erase request is granted. When debugging runs through the alternate port, the block can force a reduced-pin view of the chip in which the upper-package features are switched off.

Every pin-level input passes through a two-flop synchronizer and a stable-level filter before it can affect any state.

Top module: `prog_entry_ctrl`

## Requirements
- R1: A filtered high level on `vpp_hv_det` moves the controller from run into high-voltage programming, whatever `ssp_bit` holds. High-voltage entry takes priority when both entry conditions are present. `mode` encodes run as 0, high-voltage programming as 1 and single-supply programming as 2.
- R2: Single-supply programming (mode 2) is entered only when `ssp_bit` is 1, `vpp_mid_det` is high, `prog_req_pin` is high and no high-voltage condition is present. With `ssp_bit` at 0 the same pin levels leave the block in run.
- R3: Each programming mode returns to run once its entry condition has dropped through the filter. `core_hold` is high in both programming modes and low in run.
- R4: `pgm_gpio_en` is the inverse of `ssp_bit`, so the request pin is a general-purpose I/O only while single-supply programming is disabled.
- R5: A pulse on `cfg_wr_en` loads `cfg_wr_ssp` into `ssp_bit` only while the mode is high-voltage programming. The same pulse in run or in single-supply mode leaves `ssp_bit` unchanged. `ssp_bit` resets to parameter `SSP_RST` (default 1).
- R6: When `altport_eff` is 1, a filtered high on `alt_vpp_hv_det` also gives high-voltage entry. That input is ignored whenever `vpp_mid_det` (filtered) is high.
- R7: `altport_eff` equals `cfg_altport_bit` AND `strap_44pin`. With the strap low, the alternate-port bit reads as 0 and the alternate high-voltage input has no effect.
- R8: `emu_reduced` is high when `cfg_bkdbg_bit` is 0, `altport_eff` is 1 and the filtered `alt_cfgsel_pin` is low. While it is high, every bit of `feat_en` is 0. Otherwise `feat_en` equals `feat_req`. The bits of `feat_req`/`feat_en` are: bit0 the fourth I/O port, bit1 the fifth I/O port, bit2 the parallel slave port, bit3 the enhanced PWM steering.
- R9: In either programming mode a row erase (`erase_bulk`=0) is granted only when `erase_row_prot` is 0. A row erase of a protected row raises `erase_reject`.
- R10: A bulk erase is always granted in high-voltage mode. In single-supply mode it is granted only while `supply_in_range` is 1. No erase is granted in run. Any request that is not granted raises `erase_reject`.
- R11: A pin-level input takes effect only after its synchronized value has stayed at the new level on `STABLE_CYC` (4) consecutive clocks. A high pulse seen on 3 or fewer clocks changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vpp_hv_det | input | 1 | Programming-level voltage seen on the reset/programming pin |
| vpp_mid_det | input | 1 | Supply-level voltage seen on the reset/programming pin |
| prog_req_pin | input | 1 | Single-supply programming request pin |
| alt_vpp_hv_det | input | 1 | Programming-level voltage seen on the alternate debug port |
| alt_cfgsel_pin | input | 1 | Reduced-pin emulation selector (low selects reduced) |
| cfg_bkdbg_bit | input | 1 | Background-debug configuration bit (0 enables debug) |
| cfg_altport_bit | input | 1 | Alternate debug port enable bit |
| strap_44pin | input | 1 | High on the large-package variant |
| supply_in_range | input | 1 | Supply is inside the bulk-erase window |
| cfg_wr_en | input | 1 | Write pulse for the single-supply bit |
| cfg_wr_ssp | input | 1 | Value to write to the single-supply bit |
| erase_req | input | 1 | Erase request |
| erase_bulk | input | 1 | 1 for bulk erase, 0 for row erase |
| erase_row_prot | input | 1 | Addressed row is code-protected |
| feat_req | input | FEAT_W | Requested feature enables |
| mode | output | 2 | Current mode (0 run, 1 high-voltage, 2 single-supply) |
| core_hold | output | 1 | Keeps the core held in reset |
| pgm_gpio_en | output | 1 | Request pin is available as general-purpose I/O |
| ssp_bit | output | 1 | Single-supply programming enable bit |
| altport_eff | output | 1 | Effective alternate-port enable |
| emu_reduced | output | 1 | Reduced-pin emulation active |
| feat_en | output | FEAT_W | Gated feature enables |
| erase_grant | output | 1 | Erase request granted |
| erase_reject | output | 1 | Erase request refused |

## Verification
A wrong mode register shows up at once on `mode` and `core_hold`, and in the same cycle it changes the `erase_grant`/`erase_reject` decision for any pending request. A wrong filter state shows up as entry or exit one or more cycles away from the fixed six-clock latency, or as entry caused by a short glitch. The bench compares every output against a behavioural model on every clock, so such an offset is caught on the first cycle it appears. A wrongly accepted write to the single-supply bit shows on `ssp_bit` and `pgm_gpio_en` on the clock after the write pulse.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
// Package: shared types and index constants for the programming-entry controller.
// Assumes: encodings of pm_state_e are visible at the top's mode port.
package pe_pkg;
    typedef enum logic [1:0] {
        PM_RUN = 2'd0,
        PM_HV  = 2'd1,
        PM_LV  = 2'd2
    } pm_state_e;

    // positions of the pin-level inputs inside the filtered vector
    localparam int RAW_HV    = 0;
    localparam int RAW_MID   = 1;
    localparam int RAW_REQ   = 2;
    localparam int RAW_ALTHV = 3;
    localparam int RAW_SEL   = 4;
    localparam int RAW_NUM   = 5;
endpackage

// File: rtl/pe_filt.sv
`timescale 1ns/1ps
// Module: pe_filt
// Synchronizes one asynchronous pin level and only passes a new level once
// the synchronized value has differed from the output on STABLE_CYC
// consecutive clocks. Assumes SYNC_STAGES >= 2 and STABLE_CYC >= 2.
module pe_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_out;
    logic [CNT_W-1:0]       cnt_q;

    // shift the raw level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign sync_out = sync_q[SYNC_STAGES-1];

    // count clocks of disagreement and adopt the new level when it has held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= 1'b0;
            cnt_q <= '0;
        end else if (sync_out == dout) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            dout  <= sync_out;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R11
    filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(sync_out) == dout));
endmodule

// File: rtl/pe_mode_fsm.sv
`timescale 1ns/1ps
// Module: pe_mode_fsm
// Three-state mode machine: run, high-voltage programming and single-supply
// programming. Assumes all level inputs are already filtered, and that
// ssp_bit comes from the guarded configuration register.
module pe_mode_fsm
    import pe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hv_f,
    input  logic      mid_f,
    input  logic      req_f,
    input  logic      alt_hv_f,
    input  logic      altport_eff,
    input  logic      ssp_bit,
    output pm_state_e state_q
);
    logic      hv_entry;
    logic      lv_entry;
    pm_state_e state_d;

    // the alternate high-voltage input counts only while the main pin is not at supply level
    always_comb begin
        hv_entry = hv_f | (altport_eff & alt_hv_f & ~mid_f);
        lv_entry = ssp_bit & mid_f & req_f;
    end

    // next-state selection with high-voltage priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (hv_entry)      state_d = PM_HV;
                else if (lv_entry) state_d = PM_LV;
            end
            PM_HV: begin
                if (!hv_entry) state_d = PM_RUN;
            end
            PM_LV: begin
                if (hv_entry)      state_d = PM_HV;
                else if (!lv_entry) state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    // R1
    hv_entry_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && hv_entry) |=> (state_q == PM_HV));

    // R2
    lv_needs_ssp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_LV) |-> ssp_bit);
endmodule

// File: rtl/pe_cfg_guard.sv
`timescale 1ns/1ps
// Module: pe_cfg_guard
// Holds the single-supply programming enable bit and accepts writes to it
// only while the high-voltage programming mode is active.
// Assumes wr_en is a synchronous pulse from the programming protocol.
module pe_cfg_guard
    import pe_pkg::*;
#(
    parameter logic SSP_RST = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_e state_i,
    input  logic      wr_en,
    input  logic      wr_val,
    output logic      ssp_q
);
    // guarded write of the enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)                          ssp_q <= SSP_RST;
        else if (wr_en && state_i == PM_HV)  ssp_q <= wr_val;
    end

    // R5
    ssp_write_hv_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ssp_q != $past(ssp_q)) |-> ($past(state_i) == PM_HV));
endmodule

// File: rtl/pe_erase_ctl.sv
`timescale 1ns/1ps
// Module: pe_erase_ctl
// Grants or refuses erase requests from the current mode, the row
// protection flag and the supply window flag. Purely combinational.
module pe_erase_ctl
    import pe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_e state_i,
    input  logic      req,
    input  logic      bulk,
    input  logic      row_prot,
    input  logic      supply_ok,
    output logic      grant,
    output logic      reject
);
    logic in_prog;
    logic bulk_ok;
    logic row_ok;

    // permission terms per erase kind
    always_comb begin
        in_prog = (state_i != PM_RUN);
        bulk_ok = (state_i == PM_HV) | ((state_i == PM_LV) & supply_ok);
        row_ok  = in_prog & ~row_prot;
        grant   = req & (bulk ? bulk_ok : row_ok);
        reject  = req & ~grant;
    end

    // R10
    lv_bulk_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && bulk && state_i == PM_LV) |-> supply_ok);

    // R9
    row_prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !bulk) |-> !row_prot);
endmodule

// File: rtl/prog_entry_ctrl.sv
`timescale 1ns/1ps
// Module: prog_entry_ctrl (top)
// Filters the pin-level inputs, runs the mode machine, guards the
// single-supply enable bit, decides erase permission and gates the
// upper-package features during reduced-pin emulation.
// Assumes all inputs are synchronous to clk except the five pin levels.
module prog_entry_ctrl
    import pe_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   STABLE_CYC  = 4,
    parameter logic SSP_RST     = 1'b1,
    parameter int   FEAT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpp_hv_det,
    input  logic              vpp_mid_det,
    input  logic              prog_req_pin,
    input  logic              alt_vpp_hv_det,
    input  logic              alt_cfgsel_pin,
    input  logic              cfg_bkdbg_bit,
    input  logic              cfg_altport_bit,
    input  logic              strap_44pin,
    input  logic              supply_in_range,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_ssp,
    input  logic              erase_req,
    input  logic              erase_bulk,
    input  logic              erase_row_prot,
    input  logic [FEAT_W-1:0] feat_req,
    output logic [1:0]        mode,
    output logic              core_hold,
    output logic              pgm_gpio_en,
    output logic              ssp_bit,
    output logic              altport_eff,
    output logic              emu_reduced,
    output logic [FEAT_W-1:0] feat_en,
    output logic              erase_grant,
    output logic              erase_reject
);
    logic [RAW_NUM-1:0] raw_lvl;
    logic [RAW_NUM-1:0] flt_lvl;
    pm_state_e          state_q;

    // collect the pin levels that need filtering
    always_comb begin
        raw_lvl            = '0;
        raw_lvl[RAW_HV]    = vpp_hv_det;
        raw_lvl[RAW_MID]   = vpp_mid_det;
        raw_lvl[RAW_REQ]   = prog_req_pin;
        raw_lvl[RAW_ALTHV] = alt_vpp_hv_det;
        raw_lvl[RAW_SEL]   = alt_cfgsel_pin;
    end

    for (genvar g = 0; g < RAW_NUM; g++) begin : g_filt
        pe_filt #(
            .SYNC_STAGES (SYNC_STAGES),
            .STABLE_CYC  (STABLE_CYC)
        ) filt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_lvl[g]),
            .dout  (flt_lvl[g])
        );
    end

    pe_cfg_guard #(.SSP_RST(SSP_RST)) guard_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state_q),
        .wr_en   (cfg_wr_en),
        .wr_val  (cfg_wr_ssp),
        .ssp_q   (ssp_bit)
    );

    pe_mode_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hv_f        (flt_lvl[RAW_HV]),
        .mid_f       (flt_lvl[RAW_MID]),
        .req_f       (flt_lvl[RAW_REQ]),
        .alt_hv_f    (flt_lvl[RAW_ALTHV]),
        .altport_eff (altport_eff),
        .ssp_bit     (ssp_bit),
        .state_q     (state_q)
    );

    pe_erase_ctl erase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state_q),
        .req       (erase_req),
        .bulk      (erase_bulk),
        .row_prot  (erase_row_prot),
        .supply_ok (supply_in_range),
        .grant     (erase_grant),
        .reject    (erase_reject)
    );

    // mode reporting, pin ownership, alternate-port qualification and feature gating
    always_comb begin
        mode        = state_q;
        core_hold   = (state_q != PM_RUN);
        pgm_gpio_en = ~ssp_bit;
        altport_eff = cfg_altport_bit & strap_44pin;
        emu_reduced = ~cfg_bkdbg_bit & altport_eff & ~flt_lvl[RAW_SEL];
        feat_en     = feat_req & {FEAT_W{~emu_reduced}};
    end

    // R3
    hold_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |-> core_hold);

    // R8
    emu_features_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emu_reduced |-> (feat_en == '0));
endmodule

// File: tb/prog_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module prog_entry_ctrl_tb_top;
    localparam int FW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic vpp_hv_det = 0, vpp_mid_det = 0, prog_req_pin = 0, alt_vpp_hv_det = 0, alt_cfgsel_pin = 0;
    logic cfg_bkdbg_bit = 1, cfg_altport_bit = 0, strap_44pin = 0, supply_in_range = 0;
    logic cfg_wr_en = 0, cfg_wr_ssp = 0, erase_req = 0, erase_bulk = 0, erase_row_prot = 0;
    logic [FW-1:0] feat_req = '0;
    logic [1:0] mode;
    logic core_hold, pgm_gpio_en, ssp_bit, altport_eff, emu_reduced, erase_grant, erase_reject;
    logic [FW-1:0] feat_en;

    prog_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .vpp_hv_det(vpp_hv_det), .vpp_mid_det(vpp_mid_det),
        .prog_req_pin(prog_req_pin), .alt_vpp_hv_det(alt_vpp_hv_det), .alt_cfgsel_pin(alt_cfgsel_pin),
        .cfg_bkdbg_bit(cfg_bkdbg_bit), .cfg_altport_bit(cfg_altport_bit), .strap_44pin(strap_44pin),
        .supply_in_range(supply_in_range), .cfg_wr_en(cfg_wr_en), .cfg_wr_ssp(cfg_wr_ssp),
        .erase_req(erase_req), .erase_bulk(erase_bulk), .erase_row_prot(erase_row_prot),
        .feat_req(feat_req), .mode(mode), .core_hold(core_hold), .pgm_gpio_en(pgm_gpio_en),
        .ssp_bit(ssp_bit), .altport_eff(altport_eff), .emu_reduced(emu_reduced),
        .feat_en(feat_en), .erase_grant(erase_grant), .erase_reject(erase_reject)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: raw sample history per input, filtered levels, mode, enable bit
    bit hist [5][6];
    bit mflt [5];
    int mstate = 0;
    bit mssp = 1'b1;

    always @(posedge clk) begin
        bit raw [5];
        bit alt_e, hv_e, lv_e;
        int nst;
        raw[0] = vpp_hv_det; raw[1] = vpp_mid_det; raw[2] = prog_req_pin;
        raw[3] = alt_vpp_hv_det; raw[4] = alt_cfgsel_pin;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin
                mflt[i] = 0;
                for (int j = 0; j < 6; j++) hist[i][j] = 0;
            end
            mstate = 0;
            mssp = 1'b1;
        end else begin
            alt_e = cfg_altport_bit & strap_44pin;
            hv_e = mflt[0] | (alt_e & mflt[3] & !mflt[1]);
            lv_e = mssp & mflt[1] & mflt[2];
            nst = mstate;
            if (mstate == 0) begin
                if (hv_e) nst = 1; else if (lv_e) nst = 2;
            end else if (mstate == 1) begin
                if (!hv_e) nst = 0;
            end else begin
                if (hv_e) nst = 1; else if (!lv_e) nst = 0;
            end
            if (cfg_wr_en && mstate == 1) mssp = cfg_wr_ssp;
            mstate = nst;
            for (int i = 0; i < 5; i++) begin
                bit same;
                for (int j = 5; j > 0; j--) hist[i][j] = hist[i][j-1];
                hist[i][0] = raw[i];
                same = 1;
                for (int j = 2; j <= 5; j++) if (hist[i][j] == mflt[i]) same = 0;
                if (same) mflt[i] = !mflt[i];
            end
        end
    end

    // compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit alt_e, emu, bulk_ok, grant;
            alt_e = cfg_altport_bit & strap_44pin;
            emu = !cfg_bkdbg_bit & alt_e & !mflt[4];
            bulk_ok = (mstate == 1) | ((mstate == 2) & supply_in_range);
            grant = erase_req & (erase_bulk ? bulk_ok : ((mstate != 0) & !erase_row_prot));
            chk("R3 mode", {6'd0, mode}, 8'(mstate));
            chk("R3 core_hold", {7'd0, core_hold}, {7'd0, mstate != 0});
            chk("R5 ssp_bit", {7'd0, ssp_bit}, {7'd0, mssp});
            chk("R4 pgm_gpio_en", {7'd0, pgm_gpio_en}, {7'd0, !mssp});
            chk("R7 altport_eff", {7'd0, altport_eff}, {7'd0, alt_e});
            chk("R8 emu_reduced", {7'd0, emu_reduced}, {7'd0, emu});
            chk("R8 feat_en", {4'd0, feat_en}, {4'd0, emu ? 4'd0 : feat_req});
            chk("R9 R10 erase_grant", {7'd0, erase_grant}, {7'd0, grant});
            chk("R10 erase_reject", {7'd0, erase_reject}, {7'd0, erase_req & !grant});
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_ssp(input logic v);
        cfg_wr_en = 1; cfg_wr_ssp = v;
        tick(1);
        cfg_wr_en = 0;
        tick(1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // reset state
        chk("R3 reset mode", {6'd0, mode}, 8'd0);
        chk("R5 reset ssp", {7'd0, ssp_bit}, 8'd1);
        chk("R4 reset gpio", {7'd0, pgm_gpio_en}, 8'd0);

        // R1: high-voltage entry, then clear the enable bit
        vpp_hv_det = 1;
        tick(10);
        chk("R1 hv entry", {6'd0, mode}, 8'd1);
        chk("R3 hold hv", {7'd0, core_hold}, 8'd1);
        wr_ssp(0);
        chk("R5 write in hv", {7'd0, ssp_bit}, 8'd0);
        chk("R4 gpio after clear", {7'd0, pgm_gpio_en}, 8'd1);
        vpp_hv_det = 0;
        tick(10);
        chk("R3 hv exit", {6'd0, mode}, 8'd0);

        // R2: single-supply request with bit clear is refused
        vpp_mid_det = 1; prog_req_pin = 1;
        tick(10);
        chk("R2 no lv when bit clear", {6'd0, mode}, 8'd0);
        wr_ssp(1);
        chk("R5 write ignored in run", {7'd0, ssp_bit}, 8'd0);

        // set the bit again via high-voltage path; hv wins over lv
        vpp_hv_det = 1;
        tick(10);
        chk("R1 hv priority", {6'd0, mode}, 8'd1);
        wr_ssp(1);
        vpp_hv_det = 0;
        tick(10);
        chk("R2 lv entry", {6'd0, mode}, 8'd2);
        chk("R3 hold lv", {7'd0, core_hold}, 8'd1);

        // R5: writes in single-supply mode ignored
        wr_ssp(0);
        chk("R5 write ignored in lv", {7'd0, ssp_bit}, 8'd1);

        // R10 / R9: erase permissions in lv
        erase_req = 1; erase_bulk = 1; supply_in_range = 0;
        tick(1);
        chk("R10 lv bulk low supply", {6'd0, erase_grant, erase_reject}, 8'b01);
        supply_in_range = 1;
        tick(1);
        chk("R10 lv bulk in range", {6'd0, erase_grant, erase_reject}, 8'b10);
        erase_bulk = 0; erase_row_prot = 1;
        tick(1);
        chk("R9 protected row", {6'd0, erase_grant, erase_reject}, 8'b01);
        erase_row_prot = 0;
        tick(1);
        chk("R9 open row", {6'd0, erase_grant, erase_reject}, 8'b10);
        erase_req = 0;

        // R3: drop the request pin
        prog_req_pin = 0;
        tick(10);
        chk("R3 lv exit", {6'd0, mode}, 8'd0);
        erase_req = 1; erase_bulk = 1;
        tick(1);
        chk("R10 no erase in run", {6'd0, erase_grant, erase_reject}, 8'b01);
        erase_req = 0; vpp_mid_det = 0; supply_in_range = 0;
        tick(8);

        // R11: short glitches do nothing
        vpp_hv_det = 1; tick(3); vpp_hv_det = 0;
        tick(10);
        chk("R11 glitch ignored", {6'd0, mode}, 8'd0);
        vpp_hv_det = 1; tick(4); vpp_hv_det = 0;
        tick(3);
        chk("R11 four-clock level accepted", {6'd0, mode}, 8'd1);
        tick(10);

        // R10: bulk erase in hv needs no supply flag
        vpp_hv_det = 1; tick(10);
        erase_req = 1; erase_bulk = 1;
        tick(1);
        chk("R10 hv bulk", {6'd0, erase_grant, erase_reject}, 8'b10);
        erase_req = 0; vpp_hv_det = 0;
        tick(10);

        // R6 / R7: alternate high-voltage input
        alt_vpp_hv_det = 1; cfg_altport_bit = 1; strap_44pin = 0;
        tick(10);
        chk("R7 strap low masks", {6'd0, mode}, 8'd0);
        chk("R7 altport_eff low", {7'd0, altport_eff}, 8'd0);
        strap_44pin = 1;
        tick(2);
        chk("R6 alt entry", {6'd0, mode}, 8'd1);
        vpp_mid_det = 1;
        tick(10);
        chk("R6 alt ignored at mid level", {6'd0, mode}, 8'd0);
        vpp_mid_det = 0; alt_vpp_hv_det = 0;
        tick(10);

        // R8: reduced-pin emulation
        feat_req = 4'hF; cfg_bkdbg_bit = 0; alt_cfgsel_pin = 0;
        tick(2);
        chk("R8 emu features off", {3'd0, emu_reduced, feat_en}, 8'h10);
        alt_cfgsel_pin = 1;
        tick(10);
        chk("R8 full config", {3'd0, emu_reduced, feat_en}, 8'h0F);
        alt_cfgsel_pin = 0;
        tick(10);
        cfg_bkdbg_bit = 1;
        tick(1);
        chk("R8 debug off no emu", {3'd0, emu_reduced, feat_en}, 8'h0F);
        tick(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule